// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This block is a small memory-mapped timer with a parameterised number of independent 32-bit down counters. Each channel holds a configuration word, an interval value that is used as its reload value, and a current count that software can read. Counting is driven by tick-enable inputs: the block has four of them, standing in for four clock sources. Each channel picks one source and divides its ticks by a power of two. A channel runs either periodically or as a one-shot. All channels share one interrupt-enable word, one sticky status word and a single interrupt line.

Software programs the interval and then writes the configuration with the load-interval bit set, so that the count starts from the interval. A channel programmed with the all-ones interval in periodic mode acts as a free-running time base. When a channel is switched off, it keeps honouring two more ticks of its source before it halts. Software can time a safe restart from this guarantee.

Top module: `cdtimer`

## Requirements
- R1: After reset, every mapped register reads zero and `irq` is low.
- R2: The address map is as follows. Interrupt enable is at 0x00 and status is at 0x04. For channel n, configuration is at 0x10*n+0x10, interval at 0x10*n+0x14 and current count at 0x10*n+0x18. Every other address, including unaligned ones, reads zero, and writes to it change nothing. Enable and status bits above the channel count read zero.
- R3: The configuration word has the following fields. Bit 0 is run. Bit 1 is load-interval. Bits [3:2] are the source number. Bits [6:4] are the prescale exponent. Bit 7 is one-shot. Bit 1 always reads back 0. Writing the word with bit 1 set copies the interval into the count. The other fields read back as written. The count register cannot be written.
- R4: While a channel runs, each divided tick lowers its count by one. Ticks on the other sources have no effect, and a channel that never ran does not count.
- R5: The count steps on every 2^p-th tick of the selected source, where p is the prescale exponent. A configuration write restarts the divide phase.
- R6: In periodic mode, a divided tick at count 1 loads the interval and sets the channel's status bit. A divided tick at count 0 loads the interval and sets no status.
- R7: In one-shot mode, a divided tick at count 1 leaves the count at 0, sets the status bit and clears the run bit. The channel then ignores further ticks.
- R8: After run is written to 0, the channel still handles the next two ticks of its source, then stops.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a channel sets its bit in the same cycle as a clear of that bit, the bit ends up set.
- R10: `irq` is high exactly when some channel has both its status bit and its enable bit (bit n of 0x00) set.
- R11: With interval 0xFFFFFFFF in periodic mode, a divided tick at count 1 loads 0xFFFFFFFF, so the channel runs freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| srcTick | input | 4 | Tick enables, one per clock source |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Shared interrupt |

## Verification
The assertions assume that each bus write lasts one cycle and is aligned to a register address. They also assume that the reset is synchronous, so that no check needs history from before it. The count-movement property treats a configuration write as the only event that may set the count to an arbitrary value. The stimulus therefore makes all configuration and interval changes through single-cycle writes and never holds the write strobe across two cycles. The bench keeps ticks away from configuration writes, because a configuration write takes priority over a tick. The one deliberate exception is a status clear that lands on the same cycle as a firing tick.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;

  // configuration word bit positions (software-visible layout)
  localparam int unsigned CFG_RUN    = 0;
  localparam int unsigned CFG_LOAD   = 1;
  localparam int unsigned CFG_SRC_LO = 2;
  localparam int unsigned CFG_PRE_LO = 4;
  localparam int unsigned CFG_ONE    = 7;

  localparam int unsigned SRC_W   = 2;
  localparam int unsigned PRE_W   = 3;
  localparam int unsigned NUM_SRC = 1 << SRC_W;
  localparam int unsigned PRE_SPAN = (1 << PRE_W) - 1;

  // address map
  localparam int unsigned OFF_IEN   = 'h00;
  localparam int unsigned OFF_STAT  = 'h04;
  localparam int unsigned CH_BASE   = 'h10;
  localparam int unsigned CH_STRIDE = 'h10;
  localparam int unsigned OFF_CFG   = 'h0;
  localparam int unsigned OFF_IVL   = 'h4;
  localparam int unsigned OFF_CNT   = 'h8;

  typedef struct packed {
    logic cfgWr;
    logic ivlWr;
  } chStrobe_t;

  typedef struct packed {
    logic             oneShot;
    logic [PRE_W-1:0] pre;
    logic [SRC_W-1:0] src;
    logic             run;
  } chCfg_t;

endpackage

// File: rtl/cdtimer_chan.sv
module cdtimer_chan
  import cdtimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] tickIn,
  input  chStrobe_t          stb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  cfgRd,
  output logic [DATA_W-1:0]  ivlRd,
  output logic [DATA_W-1:0]  cntRd,
  output logic               fire
);

  chCfg_t              cfg;
  logic                active;
  logic [1:0]          stopLeft;
  logic [PRE_SPAN-1:0] preCnt;
  logic [PRE_SPAN-1:0] preMask;
  logic [DATA_W-1:0]   ivl;
  logic [DATA_W-1:0]   cnt;
  logic                srcHit;
  logic                stepTick;
  logic                atOne;
  logic                atZero;

  assign srcHit   = tickIn[cfg.src];
  assign preMask  = ~({PRE_SPAN{1'b1}} << cfg.pre);
  assign stepTick = active && srcHit && ((preCnt & preMask) == preMask);
  assign atOne    = (cnt == DATA_W'(1));
  assign atZero   = (cnt == '0);
  assign fire     = stepTick && atOne && !stb.cfgWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg      <= '0;
      active   <= 1'b0;
      stopLeft <= '0;
      preCnt   <= '0;
      ivl      <= '0;
      cnt      <= '0;
    end else begin
      if (stb.ivlWr) ivl <= wdata;
      if (stb.cfgWr) begin
        cfg.run     <= wdata[CFG_RUN];
        cfg.src     <= wdata[CFG_SRC_LO +: SRC_W];
        cfg.pre     <= wdata[CFG_PRE_LO +: PRE_W];
        cfg.oneShot <= wdata[CFG_ONE];
        preCnt      <= '0;
        if (wdata[CFG_LOAD]) cnt <= ivl;
        if (wdata[CFG_RUN]) begin
          active   <= 1'b1;
          stopLeft <= '0;
        end else if (active && stopLeft == '0) begin
          stopLeft <= 2'd2;
        end
      end else if (active && srcHit) begin
        preCnt <= preCnt + PRE_SPAN'(1);
        if (stopLeft != '0) stopLeft <= stopLeft - 2'd1;
        if (stopLeft == 2'd1) active <= 1'b0;
        if (stepTick) begin
          if (atOne) begin
            if (cfg.oneShot) begin
              cnt      <= '0;
              active   <= 1'b0;
              cfg.run  <= 1'b0;
              stopLeft <= '0;
            end else begin
              cnt <= ivl;
            end
          end else if (atZero) begin
            if (!cfg.oneShot) cnt <= ivl;
          end else begin
            cnt <= cnt - DATA_W'(1);
          end
        end
      end
    end
  end

  assign cfgRd = DATA_W'({cfg.oneShot, cfg.pre, cfg.src, 1'b0, cfg.run});
  assign ivlRd = ivl;
  assign cntRd = cnt;

endmodule

// File: rtl/cdtimer_path.sv
module cdtimer_path
  import cdtimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            srcTick,
  input  chStrobe_t [NUM_CH-1:0]        stbVec,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NUM_CH-1:0][DATA_W-1:0] cfgVec,
  output logic [NUM_CH-1:0][DATA_W-1:0] ivlVec,
  output logic [NUM_CH-1:0][DATA_W-1:0] cntVec,
  output logic [NUM_CH-1:0]             fireVec
);

  for (genvar n = 0; n < NUM_CH; n++) begin : gCh
    cdtimer_chan #(.DATA_W(DATA_W)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .tickIn (srcTick),
      .stb    (stbVec[n]),
      .wdata  (wdata),
      .cfgRd  (cfgVec[n]),
      .ivlRd  (ivlVec[n]),
      .cntRd  (cntVec[n]),
      .fire   (fireVec[n])
    );
  end

endmodule

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
  import cdtimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWe,
  input  logic [NUM_CH-1:0]             wrBits,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cfgVec,
  input  logic [NUM_CH-1:0][DATA_W-1:0] ivlVec,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cntVec,
  input  logic [NUM_CH-1:0]             fireVec,
  output chStrobe_t [NUM_CH-1:0]        stbVec,
  output logic [DATA_W-1:0]             busRdata,
  output logic [NUM_CH-1:0]             ienVec,
  output logic [NUM_CH-1:0]             statVec,
  output logic                          irq
);

  function automatic logic [ADDR_W-1:0] chAddr(input int n, input int unsigned off);
    return ADDR_W'(CH_BASE + CH_STRIDE * n + off);
  endfunction

  logic ienWr;
  logic statWr;
  logic [NUM_CH-1:0] clrMask;

  assign ienWr   = busWe && (busAddr == ADDR_W'(OFF_IEN));
  assign statWr  = busWe && (busAddr == ADDR_W'(OFF_STAT));
  assign clrMask = statWr ? wrBits : '0;

  always_comb begin
    stbVec   = '0;
    busRdata = '0;
    if (busAddr == ADDR_W'(OFF_IEN))  busRdata = DATA_W'(ienVec);
    if (busAddr == ADDR_W'(OFF_STAT)) busRdata = DATA_W'(statVec);
    for (int n = 0; n < NUM_CH; n++) begin
      if (busAddr == chAddr(n, OFF_CFG)) begin
        busRdata        = cfgVec[n];
        stbVec[n].cfgWr = busWe;
      end
      if (busAddr == chAddr(n, OFF_IVL)) begin
        busRdata        = ivlVec[n];
        stbVec[n].ivlWr = busWe;
      end
      if (busAddr == chAddr(n, OFF_CNT)) busRdata = cntVec[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienVec  <= '0;
      statVec <= '0;
    end else begin
      if (ienWr) ienVec <= wrBits;
      statVec <= (statVec & ~clrMask) | fireVec;
    end
  end

  assign irq = |(statVec & ienVec);

endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import cdtimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq
);

  chStrobe_t [NUM_CH-1:0]        stbVec;
  logic [NUM_CH-1:0][DATA_W-1:0] cfgVec;
  logic [NUM_CH-1:0][DATA_W-1:0] ivlVec;
  logic [NUM_CH-1:0][DATA_W-1:0] cntVec;
  logic [NUM_CH-1:0]             fireVec;
  logic [NUM_CH-1:0]             ienVec;
  logic [NUM_CH-1:0]             statVec;

  cdtimer_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .wrBits   (busWdata[NUM_CH-1:0]),
    .cfgVec   (cfgVec),
    .ivlVec   (ivlVec),
    .cntVec   (cntVec),
    .fireVec  (fireVec),
    .stbVec   (stbVec),
    .busRdata (busRdata),
    .ienVec   (ienVec),
    .statVec  (statVec),
    .irq      (irq)
  );

  cdtimer_path #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .srcTick (srcTick),
    .stbVec  (stbVec),
    .wdata   (busWdata),
    .cfgVec  (cfgVec),
    .ivlVec  (ivlVec),
    .cntVec  (cntVec),
    .fireVec (fireVec)
  );

endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk
  import cdtimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic                          busWe,
  input logic [NUM_CH-1:0]             clrBits,
  input logic [DATA_W-1:0]             busRdata,
  input logic                          irq,
  input logic [NUM_CH-1:0][DATA_W-1:0] cfgVec,
  input logic [NUM_CH-1:0][DATA_W-1:0] ivlVec,
  input logic [NUM_CH-1:0][DATA_W-1:0] cntVec,
  input logic [NUM_CH-1:0]             fireVec,
  input logic [NUM_CH-1:0]             statVec
);

  function automatic logic [ADDR_W-1:0] regAt(input int n, input int unsigned off);
    return ADDR_W'(CH_BASE + CH_STRIDE * n + off);
  endfunction

  logic isMapped;
  always_comb begin
    isMapped = (busAddr == ADDR_W'(OFF_IEN)) || (busAddr == ADDR_W'(OFF_STAT));
    for (int n = 0; n < NUM_CH; n++) begin
      if (busAddr == regAt(n, OFF_CFG) || busAddr == regAt(n, OFF_IVL) ||
          busAddr == regAt(n, OFF_CNT))
        isMapped = 1'b1;
    end
  end

  // R2: unmapped addresses read zero
  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !isMapped |-> busRdata == '0);

  // R10: a rising interrupt needs a fresh event or an enable write
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(|fireVec) || $past(busWe && busAddr == ADDR_W'(OFF_IEN))));

  for (genvar n = 0; n < NUM_CH; n++) begin : gChk
    // R2: channel registers appear at their decoded addresses
    p_read_cfg_r2: assert property (@(posedge clk) disable iff (!rstN)
      busAddr == regAt(n, OFF_CFG) |-> busRdata == cfgVec[n]);
    p_read_ivl_r2: assert property (@(posedge clk) disable iff (!rstN)
      busAddr == regAt(n, OFF_IVL) |-> busRdata == ivlVec[n]);
    p_read_cnt_r2: assert property (@(posedge clk) disable iff (!rstN)
      busAddr == regAt(n, OFF_CNT) |-> busRdata == cntVec[n]);

    // R4: without a configuration write the count holds, steps down or reloads
    p_count_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
      !(busWe && busAddr == regAt(n, OFF_CFG)) |=>
        (cntVec[n] == $past(cntVec[n]) ||
         cntVec[n] == $past(cntVec[n]) - DATA_W'(1) ||
         cntVec[n] == $past(ivlVec[n])));

    // R6: periodic expiry reloads the interval
    p_periodic_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
      fireVec[n] && !cfgVec[n][CFG_ONE] |=> cntVec[n] == $past(ivlVec[n]));

    // R7: one-shot expiry parks at zero with run cleared
    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
      fireVec[n] && cfgVec[n][CFG_ONE] |=> !cfgVec[n][CFG_RUN] && cntVec[n] == '0);

    // R9: an expiry always leaves the status bit set
    p_fire_sets_stat_r9: assert property (@(posedge clk) disable iff (!rstN)
      fireVec[n] |=> statVec[n]);

    // R9: a clear without a simultaneous expiry empties the bit
    p_stat_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
      busWe && busAddr == ADDR_W'(OFF_STAT) && clrBits[n] && !fireVec[n] |=> !statVec[n]);
  end

endmodule

bind cdtimer cdtimer_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .clrBits  (busWdata[NUM_CH-1:0]),
  .busRdata (busRdata),
  .irq      (irq),
  .cfgVec   (cfgVec),
  .ivlVec   (ivlVec),
  .cntVec   (cntVec),
  .fireVec  (fireVec),
  .statVec  (statVec)
);

// File: tb/cdtimer_bench.sv
module cdtimer_bench;
  localparam int NUM_CH = 2;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [3:0]        srcTick = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic              irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cdtimer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cdtimer (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] cfgA(input int n); return ADDR_W'(16 * n + 16); endfunction
  function automatic logic [ADDR_W-1:0] ivlA(input int n); return ADDR_W'(16 * n + 20); endfunction
  function automatic logic [ADDR_W-1:0] cntA(input int n); return ADDR_W'(16 * n + 24); endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input string what, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #2;
    check(req, what, busRdata, exp);
  endtask

  task automatic irqChk(input string req, input logic exp);
    @(negedge clk);
    #2;
    check(req, "irq", {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic tick(input logic [3:0] v);
    @(negedge clk);
    srcTick = v;
    @(negedge clk);
    srcTick = '0;
  endtask

  // expected count after n selected-source ticks from a fresh load
  task automatic model(input logic [31:0] ivl, input int pre, input bit one, input int n,
                       output logic [31:0] cnt, output bit fired);
    int ph;
    bit running;
    cnt = ivl; ph = 0; running = 1'b1; fired = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (running) begin
        ph++;
        if (ph == (1 << pre)) begin
          ph = 0;
          if (cnt == 1) begin
            fired = 1'b1;
            if (one) begin cnt = 0; running = 1'b0; end
            else cnt = ivl;
          end else if (cnt == 0) begin
            if (!one) cnt = ivl;
          end else begin
            cnt = cnt - 1;
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdChk("R1", "ien", 8'h00, 0);
    rdChk("R1", "status", 8'h04, 0);
    for (int n = 0; n < NUM_CH; n++) begin
      rdChk("R1", "cfg", cfgA(n), 0);
      rdChk("R1", "ivl", ivlA(n), 0);
      rdChk("R1", "cnt", cntA(n), 0);
    end
    irqChk("R1", 1'b0);

    // R2: unmapped addresses
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'h0C, 32'hFFFFFFFF);
    wr(8'h1C, 32'hFFFFFFFF);
    wr(8'h30, 32'hFFFFFFFF);
    wr(8'h11, 32'hFFFFFFFF);
    rdChk("R2", "rd 08", 8'h08, 0);
    rdChk("R2", "rd 0C", 8'h0C, 0);
    rdChk("R2", "rd 1C", 8'h1C, 0);
    rdChk("R2", "rd 30", 8'h30, 0);
    rdChk("R2", "rd 11", 8'h11, 0);
    rdChk("R2", "ien untouched", 8'h00, 0);
    rdChk("R2", "cfg0 untouched", cfgA(0), 0);
    rdChk("R2", "ivl0 untouched", ivlA(0), 0);

    // R3: load bit and field readback; count not writable
    wr(ivlA(0), 5);
    wr(cfgA(0), 32'h02);
    rdChk("R3", "cnt after load", cntA(0), 5);
    rdChk("R3", "load bit reads 0", cfgA(0), 0);
    wr(cfgA(0), 32'hF6);
    rdChk("R3", "fields readback", cfgA(0), 32'hF4);
    wr(cntA(0), 32'h1234);
    rdChk("R3", "count write ignored", cntA(0), 5);
    wr(cfgA(0), 32'h00);

    // R4: source selection
    wr(cfgA(0), 32'h07);
    tick(4'b0001);
    rdChk("R4", "other source", cntA(0), 5);
    tick(4'b0010);
    rdChk("R4", "selected source", cntA(0), 4);
    tick(4'b1101);
    rdChk("R4", "other sources", cntA(0), 4);
    wr(ivlA(1), 9);
    wr(cfgA(1), 32'h02);
    tick(4'b1111);
    rdChk("R4", "idle channel", cntA(1), 9);
    rdChk("R4", "ch0 with all", cntA(0), 3);

    // R8: delayed stop
    wr(cfgA(0), 32'h04);
    rdChk("R8", "cfg run cleared", cfgA(0), 32'h04);
    tick(4'b0010);
    rdChk("R8", "first tick after stop", cntA(0), 2);
    tick(4'b0010);
    rdChk("R8", "second tick after stop", cntA(0), 1);
    tick(4'b0010);
    rdChk("R8", "third tick ignored", cntA(0), 1);
    rdChk("R8", "no status", 8'h04, 0);

    // R5: prescaler
    wr(ivlA(0), 10);
    wr(cfgA(0), 32'h27);
    tick(4'b0010); tick(4'b0010); tick(4'b0010);
    rdChk("R5", "three of four", cntA(0), 10);
    tick(4'b0010);
    rdChk("R5", "fourth tick", cntA(0), 9);

    // R6: periodic reload
    wr(ivlA(1), 3);
    wr(cfgA(1), 32'h03);
    tick(4'b0001); tick(4'b0001);
    rdChk("R6", "count at one", cntA(1), 1);
    rdChk("R6", "no status yet", 8'h04, 0);
    tick(4'b0001);
    rdChk("R6", "reloaded", cntA(1), 3);
    rdChk("R6", "status set", 8'h04, 2);

    // R11: free run wrap
    wr(8'h04, 2);
    wr(ivlA(1), 1);
    wr(cfgA(1), 32'h03);
    wr(ivlA(1), 32'hFFFFFFFF);
    tick(4'b0001);
    rdChk("R11", "wrap to all ones", cntA(1), 32'hFFFFFFFF);
    rdChk("R11", "status on wrap", 8'h04, 2);
    tick(4'b0001);
    rdChk("R11", "keeps counting", cntA(1), 32'hFFFFFFFE);

    // R7: one-shot
    wr(ivlA(1), 2);
    wr(8'h04, 2);
    wr(cfgA(1), 32'h83);
    tick(4'b0001);
    rdChk("R7", "step", cntA(1), 1);
    tick(4'b0001);
    rdChk("R7", "parked at zero", cntA(1), 0);
    rdChk("R7", "status", 8'h04, 2);
    rdChk("R7", "run cleared", cfgA(1), 32'h80);
    tick(4'b0001);
    rdChk("R7", "ignored afterwards", cntA(1), 0);

    // R6: periodic start from zero
    wr(8'h04, 2);
    wr(cfgA(1), 32'h01);
    rdChk("R6", "start at zero", cntA(1), 0);
    tick(4'b0001);
    rdChk("R6", "zero loads interval", cntA(1), 2);
    rdChk("R6", "zero sets no status", 8'h04, 0);
    tick(4'b0001);
    tick(4'b0001);
    rdChk("R6", "reload after one", cntA(1), 2);
    rdChk("R6", "status after one", 8'h04, 2);

    // R9 / R10: clear semantics and interrupt
    irqChk("R10", 1'b0);
    wr(8'h00, 32'hFFFFFFFF);
    rdChk("R2", "ien high bits zero", 8'h00, 3);
    wr(8'h00, 2);
    irqChk("R10", 1'b1);
    wr(8'h04, 0);
    rdChk("R9", "write zero keeps", 8'h04, 2);
    wr(8'h04, 1);
    rdChk("R9", "other bit keeps", 8'h04, 2);
    wr(8'h04, 2);
    rdChk("R9", "cleared", 8'h04, 0);
    irqChk("R10", 1'b0);
    wr(8'h00, 1);
    tick(4'b0001);
    rdChk("R9", "count one before race", cntA(1), 1);
    @(negedge clk);
    busAddr = 8'h04; busWe = 1'b1; busWdata = 2; srcTick = 4'b0001;
    @(negedge clk);
    busWe = 1'b0; srcTick = '0;
    rdChk("R9", "set wins over clear", 8'h04, 2);
    irqChk("R10", 1'b0);
    wr(8'h00, 3);
    irqChk("R10", 1'b1);
    wr(8'h04, 2);
    irqChk("R10", 1'b0);
    wr(8'h00, 0);

    // random configurations against the model
    for (int it = 0; it < 40; it++) begin
      int ch, src, pre, n, nSel;
      bit one, fired;
      logic [31:0] ivl, expCnt;
      logic [3:0] v;
      ch  = int'($urandom % NUM_CH);
      src = int'($urandom % 4);
      pre = int'($urandom % 3);
      one = 1'($urandom % 2);
      ivl = 32'(1 + $urandom % 12);
      n   = int'($urandom % 40);
      nSel = 0;
      wr(ivlA(ch), ivl);
      wr(8'h04, 32'(1 << ch));
      wr(cfgA(ch), {24'b0, one, 3'(pre), 2'(src), 2'b11});
      for (int i = 0; i < n; i++) begin
        v = 4'($urandom) & ~(4'b1 << src);
        if ($urandom % 4 != 0) begin
          v[src] = 1'b1;
          nSel++;
        end
        tick(v);
      end
      model(ivl, pre, one, nSel, expCnt, fired);
      rdChk("R4", "random count", cntA(ch), expCnt);
      @(negedge clk);
      busAddr = 8'h04;
      #2;
      check("R6", "random status", {31'b0, busRdata[ch]}, {31'b0, fired});
      rdChk("R5", "random cfg", cfgA(ch),
            {24'b0, one, 3'(pre), 2'(src), 1'b0, !(one && fired)});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule